// File: doc/BRIEF.md
# Serial Transmitter with Automatic Request-to-Send

This block turns queued characters into an asynchronous serial bit stream. A small transmit queue of up to four entries accepts characters of 5 to 9 data bits. The framing engine sends each one as a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from a rate-enable pulse supplied by an external divider. In oversampled mode one bit lasts sixteen pulses. In direct mode one bit lasts a single pulse, which suits an external serial clock.

The request-to-send line has three modes. In manual mode it simply mirrors a control bit, and characters go out as soon as they are queued. In the two automatic modes the engine raises the line one full bit time ahead of the first start bit. It keeps the line up while characters follow one another and drops it when the stop bit of the last queued character ends. The fully automatic mode also waits for clear-to-send before it begins each new character, but a character already on the line always completes. The semi-automatic mode ignores clear-to-send.

Top module: `uart_tx_autorts`

## Requirements
- R1: After reset txd is 1, rts is 0, fifo_empty is 1, fifo_full is 0 and tx_idle is 1.
- R2: A frame is one start bit at 0, then N data bits least significant first, where N = 5 + len_sel for len_sel 0..4 and N = 9 for len_sel 5..7, then one stop bit at 1, or two when two_stop is 1. Data bits above N are ignored.
- R3: With par_en = 1 a parity bit follows the data bits. par_kind 00 makes the count of ones over data plus parity even, 01 makes it odd, 10 sends 1 and 11 sends 0.
- R4: With ovs_mode = 1 every bit, including the lead-in, lasts 16 bit_tick pulses. With ovs_mode = 0 it lasts one pulse.
- R5: The queue holds at most depth_sel + 1 entries and asserts fifo_full while it holds that many. A write while fifo_full is 1 is dropped. Characters leave in the order they were written.
- R6: With rts_mode = 00, rts equals rts_sw, and a queued character starts on the next bit_tick whatever the level of cts.
- R7: With rts_mode other than 00, rts rises exactly one bit time before the first start bit that follows idle, provided clear-to-send does not hold the start back.
- R8: With rts_mode other than 00, rts stays 1 between consecutive characters. It returns to 0, with tx_idle at 1, when the last stop bit ends and the queue is empty.
- R9: With rts_mode = 10 or 11, no character starts while cts is 0. A character already started completes, and rts stays 1 while a queued character waits.
- R10: With rts_mode = 01, cts has no effect on transmission.
- R11: Whenever the engine is idle, txd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-rate enable pulse |
| ovs_mode | input | 1 | 1: 16 pulses per bit, 0: 1 pulse per bit |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 9 | Character to queue |
| depth_sel | input | 2 | Queue depth minus one |
| len_sel | input | 3 | Data length select (N = 5 + len_sel, max 9) |
| par_en | input | 1 | Parity bit enable |
| par_kind | input | 2 | 00 even, 01 odd, 10 one, 11 zero |
| two_stop | input | 1 | Two stop bits when 1 |
| rts_mode | input | 2 | 00 manual, 01 semi-automatic, 1x automatic |
| rts_sw | input | 1 | Request-to-send level in manual mode |
| cts | input | 1 | Clear-to-send, 1 = peer ready |
| txd | output | 1 | Serial data out |
| rts | output | 1 | Request-to-send |
| fifo_empty | output | 1 | Queue holds no character |
| fifo_full | output | 1 | Queue holds depth_sel + 1 characters |
| tx_idle | output | 1 | Engine is idle |

## Verification
The hardest case to reach is clear-to-send falling while a character is already on the line and another one is queued behind it. The stimulus queues two characters with clear-to-send high and watches txd until the first start bit appears. It then drops clear-to-send at once, so the first frame has to finish while the second is held with the request line still high. The same blocked state also fills the queue to a reduced depth, so the drop of a surplus write can be seen in the frames that later come out.

// File: rtl/uart_tx_autorts.sv
module uart_tx_autorts #(
  parameter int DEPTH = 4,
  parameter int DW    = 9,
  parameter int OVS   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 ovs_mode,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] depth_sel,
  input  logic [2:0]           len_sel,
  input  logic                 par_en,
  input  logic [1:0]           par_kind,
  input  logic                 two_stop,
  input  logic [1:0]           rts_mode,
  input  logic                 rts_sw,
  input  logic                 cts,
  output logic                 txd,
  output logic                 rts,
  output logic                 fifo_empty,
  output logic                 fifo_full,
  output logic                 tx_idle
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             state;
  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   cnt, limit;
  logic [SW-1:0]   sub;
  logic [IW-1:0]   idx, nbits;
  logic [DW-1:0]   shreg, head_m;
  logic            par_q, par_calc, stop2;
  logic            bit_end, go_ok, load, push, pop;

  assign limit      = (int'(depth_sel) + 1 > DEPTH) ? CW'(DEPTH) : CW'(depth_sel) + CW'(1);
  assign fifo_empty = (cnt == '0);
  assign fifo_full  = (cnt >= limit);
  assign push       = wr_en && !fifo_full;
  assign pop        = load;

  assign nbits = (int'(len_sel) > DW - 5) ? IW'(DW) : IW'(len_sel) + IW'(5);

  always_comb begin
    for (int i = 0; i < DW; i++)
      head_m[i] = (IW'(i) < nbits) ? mem[rptr][i] : 1'b0;
  end

  always_comb begin
    case (par_kind)
      2'b00:   par_calc = ^head_m;
      2'b01:   par_calc = ~^head_m;
      2'b10:   par_calc = 1'b1;
      default: par_calc = 1'b0;
    endcase
  end

  assign bit_end = bit_tick && (!ovs_mode || sub == SW'(OVS - 1));
  assign go_ok   = !fifo_empty && (!rts_mode[1] || cts);
  assign load    = (state == S_IDLE && bit_tick && !fifo_empty && rts_mode == 2'b00)
                || (state == S_LEAD && bit_end && go_ok)
                || (state == S_STOP && bit_end && (!two_stop || stop2) && go_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sub   <= '0;
      idx   <= '0;
      shreg <= '0;
      par_q <= 1'b0;
      stop2 <= 1'b0;
    end else begin
      if (state == S_IDLE)   sub <= '0;
      else if (bit_tick)     sub <= bit_end ? '0 : sub + SW'(1);

      if (load) begin
        shreg <= head_m;
        par_q <= par_calc;
      end

      case (state)
        S_IDLE:
          if (bit_tick && !fifo_empty) state <= (rts_mode == 2'b00) ? S_START : S_LEAD;
        S_LEAD:
          if (load) state <= S_START;
        S_START:
          if (bit_end) begin
            state <= S_DATA;
            idx   <= '0;
          end
        S_DATA:
          if (bit_end) begin
            shreg <= shreg >> 1;
            if (idx == nbits - IW'(1)) begin
              state <= par_en ? S_PAR : S_STOP;
              stop2 <= 1'b0;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        S_PAR:
          if (bit_end) begin
            state <= S_STOP;
            stop2 <= 1'b0;
          end
        S_STOP:
          if (bit_end) begin
            if (two_stop && !stop2)                 stop2 <= 1'b1;
            else if (load)                          state <= S_START;
            else if (!fifo_empty && rts_mode != 0)  state <= S_LEAD;
            else                                    state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = shreg[0];
      S_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
  end

  assign tx_idle = (state == S_IDLE);
  assign rts     = (rts_mode == 2'b00) ? rts_sw : (state != S_IDLE);
endmodule

// File: rtl/uart_tx_autorts_chk.sv
module uart_tx_autorts_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       rts,
  input logic       tx_idle,
  input logic       fifo_empty,
  input logic       fifo_full,
  input logic [1:0] rts_mode
);
  assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> !tx_idle);

  assert_no_data_without_rts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_mode != 2'b00 && !rts) |-> txd);

  assert_rts_leads_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_mode != 2'b00 && $rose(rts)) |=> txd);

  assert_empty_not_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_full);

  assert_pop_starts_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_empty) |-> !tx_idle);

  assert_rts_drop_at_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_mode != 2'b00 && $past(rts_mode) != 2'b00 && $fell(rts)) |-> (tx_idle && txd));
endmodule

bind uart_tx_autorts uart_tx_autorts_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .rts(rts), .tx_idle(tx_idle),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .rts_mode(rts_mode)
);

// File: tb/uart_tx_autorts_tb.sv
module uart_tx_autorts_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, bit_tick, ovs_mode, wr_en, par_en, two_stop, rts_sw, cts;
  logic [8:0] wr_data;
  logic [1:0] depth_sel, par_kind, rts_mode;
  logic [2:0] len_sel;
  wire        txd, rts, fifo_empty, fifo_full, tx_idle;

  int checks = 0;
  int fails  = 0;
  int tper   = 2;
  bit lead_chk = 1'b0;
  logic [8:0] exp_q[$];

  uart_tx_autorts u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ovs_mode(ovs_mode),
    .wr_en(wr_en), .wr_data(wr_data), .depth_sel(depth_sel), .len_sel(len_sel),
    .par_en(par_en), .par_kind(par_kind), .two_stop(two_stop), .rts_mode(rts_mode),
    .rts_sw(rts_sw), .cts(cts), .txd(txd), .rts(rts), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .tx_idle(tx_idle)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int bitc_f();
    return ovs_mode ? 16 * tper : tper;
  endfunction

  function automatic int nb_f();
    return (len_sel > 3'd4) ? 9 : 5 + int'(len_sel);
  endfunction

  function automatic logic [8:0] msk(input logic [8:0] v);
    logic [8:0] r;
    r = '0;
    for (int i = 0; i < 9; i++) if (i < nb_f()) r[i] = v[i];
    return r;
  endfunction

  initial begin
    int tc;
    tc = 0;
    bit_tick = 1'b0;
    forever begin
      @(negedge clk);
      tc++;
      if (tc >= tper) begin tc = 0; bit_tick = 1'b1; end
      else bit_tick = 1'b0;
    end
  end

  task automatic rx_frame(input bit do_lead, input int lead);
    int bitc, nb;
    logic [8:0] d, e;
    logic st, p, s1, s2, ep;
    bitc = bitc_f();
    nb = nb_f();
    if (do_lead) check(lead == bitc, "R7 lead-in cycles", lead, bitc);
    repeat (bitc / 2) @(negedge clk);
    st = txd;
    d = '0;
    for (int i = 0; i < nb; i++) begin
      repeat (bitc) @(negedge clk);
      d[i] = txd;
    end
    p = 1'b0;
    if (par_en) begin repeat (bitc) @(negedge clk); p = txd; end
    repeat (bitc) @(negedge clk);
    s1 = txd;
    s2 = 1'b1;
    if (two_stop) begin repeat (bitc) @(negedge clk); s2 = txd; end
    if (exp_q.size() == 0) begin
      check(1'b0, "R5 unexpected frame", int'(d), -1);
    end else begin
      e = exp_q.pop_front();
      check(st == 1'b0, "R2 start bit", st, 0);
      check(d == e, "R2/R4 data bits", int'(d), int'(e));
      if (par_en) begin
        case (par_kind)
          2'b00: ep = ^e;
          2'b01: ep = ~^e;
          2'b10: ep = 1'b1;
          default: ep = 1'b0;
        endcase
        check(p == ep, "R3 parity bit", p, ep);
      end
      check(s1 && s2, "R2 stop bits", {s1, s2}, 3);
      if (rts_mode == 2'b00) begin
        check(rts == rts_sw, "R6 rts follows rts_sw", rts, rts_sw);
      end else if (exp_q.size() == 0) begin
        repeat (bitc / 2 + 2) @(negedge clk);
        check(rts == 1'b0 && tx_idle, "R8 rts drop after drain", {rts, tx_idle}, 1);
      end else begin
        check(rts == 1'b1, "R8 rts held between chars", rts, 1);
      end
    end
  endtask

  initial begin
    logic pt, pr;
    int pc, rc;
    bit fr;
    pt = 1'b1; pr = 1'b0; pc = 0; rc = 0; fr = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      pc++;
      if (rts && !pr) begin fr = 1'b1; rc = pc; end
      pr = rts;
      if (pt && !txd) begin
        rx_frame(fr && lead_chk && rts_mode != 2'b00, pc - rc);
        fr = 1'b0;
        pr = rts;
      end
      pt = txd;
    end
  end

  task automatic send(input logic [8:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    exp_q.push_back(msk(v));
  endtask

  task automatic send_drop(input logic [8:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 30000) begin @(negedge clk); t++; end
    repeat (2 * bitc_f() + 4) @(negedge clk);
    check(exp_q.size() == 0, {tag, " frames received"}, exp_q.size(), 0);
    check(tx_idle && txd, "R11 idle line high", {tx_idle, txd}, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ovs_mode = 1'b1; wr_en = 1'b0; wr_data = '0; depth_sel = 2'd3;
    len_sel = 3'd3; par_en = 1'b0; par_kind = 2'b00; two_stop = 1'b0;
    rts_mode = 2'b00; rts_sw = 1'b0; cts = 1'b0;
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(rts == 1'b0, "R1 rts", rts, 0);
    check(fifo_empty == 1'b1, "R1 fifo_empty", fifo_empty, 1);
    check(fifo_full == 1'b0, "R1 fifo_full", fifo_full, 0);
    check(tx_idle == 1'b1, "R1 tx_idle", tx_idle, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 manual mode, cts low does not hold anything back
    send(9'h0A5);
    send(9'h13C);
    check(rts == 1'b0, "R6 rts low with rts_sw 0", rts, 0);
    drain("R6");
    rts_sw = 1'b1;
    @(negedge clk);
    check(rts == 1'b1, "R6 rts high with rts_sw 1", rts, 1);
    send(9'h05A);
    drain("R6");

    // R2/R3 lengths, parity kinds, stop counts
    len_sel = 3'd2; par_en = 1'b1; par_kind = 2'b00; two_stop = 1'b1;
    send(9'h055); send(9'h00F);
    drain("R3 even");
    par_kind = 2'b01; two_stop = 1'b0;
    send(9'h055); send(9'h007);
    drain("R3 odd");
    par_kind = 2'b10; len_sel = 3'd0;
    send(9'h0F6);
    drain("R3 mark");
    par_kind = 2'b11; len_sel = 3'd4;
    send(9'h1A5);
    drain("R3 space");
    par_en = 1'b0; len_sel = 3'd7;
    send(9'h153);
    drain("R2 length 9");

    // R7/R8 automatic mode, back to back
    len_sel = 3'd3; rts_mode = 2'b10; cts = 1'b1; lead_chk = 1'b1;
    send(9'h011); send(9'h0C3); send(9'h07E);
    drain("R8");

    // R9 blocked by cts, then released
    lead_chk = 1'b0; cts = 1'b0;
    send(9'h099);
    repeat (5 * bitc_f()) @(negedge clk);
    check(txd && rts && !fifo_empty && !tx_idle, "R9 start held while cts low",
          {txd, rts, fifo_empty, tx_idle}, 12);
    cts = 1'b1;
    drain("R9");

    // R9 cts drops mid-frame
    send(9'h0AA); send(9'h055);
    while (txd) @(negedge clk);
    cts = 1'b0;
    while (exp_q.size() != 1) @(negedge clk);
    repeat (3 * bitc_f()) @(negedge clk);
    check(txd && rts && !fifo_empty, "R9 in-progress completes, next waits",
          {txd, rts, fifo_empty}, 6);
    cts = 1'b1;
    drain("R9");

    // R10 semi-automatic ignores cts
    rts_mode = 2'b01; cts = 1'b0; lead_chk = 1'b1;
    send(9'h0E1);
    drain("R10");

    // R5 depth limit and dropped write
    rts_mode = 2'b10; cts = 1'b0; lead_chk = 1'b0; depth_sel = 2'd1;
    send(9'h021); send(9'h042);
    check(fifo_full == 1'b1, "R5 full at depth 2", fifo_full, 1);
    send_drop(9'h0FF);
    check(fifo_full == 1'b1 && !fifo_empty, "R5 still full after drop", fifo_full, 1);
    cts = 1'b1;
    drain("R5");
    depth_sel = 2'd0; cts = 1'b0;
    send(9'h066);
    check(fifo_full == 1'b1, "R5 full at depth 1", fifo_full, 1);
    send_drop(9'h0F0);
    cts = 1'b1;
    drain("R5");
    depth_sel = 2'd3;

    // R4 one pulse per bit
    ovs_mode = 1'b0; tper = 4; rts_mode = 2'b10; cts = 1'b1; lead_chk = 1'b1;
    par_en = 1'b1; par_kind = 2'b01;
    send(9'h0B4); send(9'h02D);
    drain("R4 auto 1x");
    rts_mode = 2'b00; lead_chk = 1'b0;
    send(9'h0C7);
    drain("R4 manual 1x");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule